// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block turns a reference clock of any of several common frequencies into a steady one-per-microsecond enable. A programmable ratio, packed as an increment and a modulus in one register, drives a phase accumulator. Each reference cycle adds the increment to the accumulator. When the sum reaches the modulus, the block issues a tick and keeps the remainder. Because of this, clocks whose frequency is not a whole number of megahertz still give an average of exactly one tick per microsecond.

Every tick advances a free-running up-counter. Software reads the counter through a small register port. A hold bit in that port stops the counter without stopping the tick. The tick is also sent out as a one-cycle strobe that neighbouring event timers can use as their count enable.

Top module: `us_timebase`

## Requirements
- R1: After reset the counter reads 0, the ratio register reads 0x000B, the hold register reads 0 and the tick output is low.
- R2: The ratio register holds the increment minus one in bits [15:8] and the modulus minus one in bits [7:0]. With the reset value 0x000B, the first tick comes on the 12th rising edge after reset is released, and a tick follows every 12 edges after that.
- R3: Ratio 0x045F (increment 5, modulus 96) gives exactly 5 ticks in every 96 edges, spaced 20, 19, 19, 19, 19 edges apart from a cleared accumulator.
- R4: Ratio 0x000C gives one tick every 13 edges, and ratio 0x0019 gives one tick every 26 edges.
- R5: When the increment is greater than or equal to the modulus, the tick is high on every edge.
- R6: Each tick adds one to the counter on the same edge that raises the tick. The counter wraps modulo 2^CNT_W.
- R7: While bit 0 of the hold register (offset 0x4C) is 1, the counter keeps its value and reads return that value. Ticks still occur. Clearing the bit lets counting resume from the held value.
- R8: A write to the ratio register (offset 0x14) clears the accumulator. No tick occurs on the write edge, even if one was due there. The next tick follows a full period of the new ratio.
- R9: Writes to the counter offset (0x10) have no effect. Only bits [15:0] of the ratio register and bit 0 of the hold register are stored, and unused bits read as zero. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wen | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| us_tick | output | 1 | One-cycle strobe per microsecond |

## Verification
The ratio-write path and the tick path can act on the same edge. The bench provokes this by watching its own accumulator model and writing the ratio register exactly when the model predicts a tick on the next edge. The result is judged by a per-edge scoreboard: that edge must show no tick and no counter step, and the next tick must come one full new period later. A second collision sets the hold bit on an edge that also ticks. That counter step must still happen, and every later step must be held.

// File: rtl/us_timebase_pkg.sv
package us_timebase_pkg;
   // byte offsets of the software-visible registers
   localparam int unsigned OFF_COUNT = 'h10;
   localparam int unsigned OFF_RATIO = 'h14;
   localparam int unsigned OFF_HOLD  = 'h4C;
endpackage

// File: rtl/us_ratio_accum.sv
module us_ratio_accum #(
   parameter int FIELD_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*FIELD_W-1:0] ratio,
   input  logic                 clr,
   output logic                 step,
   output logic                 tick
);
   localparam int D_W = FIELD_W + 1;
   localparam int S_W = FIELD_W + 2;
   localparam logic [D_W-1:0] ONE = D_W'(1);

   logic [D_W-1:0] inc_v, mod_v, acc_q, acc_d;
   logic [S_W-1:0] sum;
   logic           tick_q;

   assign inc_v = {1'b0, ratio[2*FIELD_W-1:FIELD_W]} + ONE;
   assign mod_v = {1'b0, ratio[FIELD_W-1:0]} + ONE;
   assign sum   = {1'b0, acc_q} + {1'b0, inc_v};

   always_comb begin
      step  = 1'b0;
      acc_d = acc_q;
      if (clr) begin
         acc_d = '0;
      end else if (inc_v >= mod_v) begin
         step  = 1'b1;
         acc_d = '0;
      end else if (sum >= {1'b0, mod_v}) begin
         step  = 1'b1;
         acc_d = D_W'(sum - {1'b0, mod_v});
      end else begin
         acc_d = D_W'(sum);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         acc_q  <= acc_d;
         tick_q <= step;
      end
   end

   assign tick = tick_q;

   // R8
   clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) clr |=> !tick);
   // R3
   acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_q < mod_v);
   // R5
   fast_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_v >= mod_v) && !clr |=> tick);
endmodule

// File: rtl/us_counter.sv
module us_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             hold,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (inc && !hold) cnt_q <= cnt_q + ONE;
   end

   assign cnt = cnt_q;

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !hold |=> cnt == $past(cnt) + ONE);
   // R7
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) hold |=> $stable(cnt));
endmodule

// File: rtl/us_regfile.sv
module us_regfile
   import us_timebase_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 32,
   parameter int          FIELD_W   = 8,
   parameter int unsigned RST_RATIO = 'h000B
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wen,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [DATA_W-1:0]    cnt_rd,
   output logic [2*FIELD_W-1:0] ratio,
   output logic                 hold,
   output logic                 ratio_wr,
   output logic [DATA_W-1:0]    rdata
);
   localparam int CFG_W = 2 * FIELD_W;
   localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFF_COUNT);
   localparam logic [ADDR_W-1:0] A_RATIO = ADDR_W'(OFF_RATIO);
   localparam logic [ADDR_W-1:0] A_HOLD  = ADDR_W'(OFF_HOLD);

   logic [CFG_W-1:0] ratio_q;
   logic             hold_q;
   logic             hold_wr;
   logic             unused_wdata;

   assign ratio_wr     = wen && (addr == A_RATIO);
   assign hold_wr      = wen && (addr == A_HOLD);
   assign unused_wdata = ^wdata[DATA_W-1:CFG_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q <= CFG_W'(RST_RATIO);
         hold_q  <= 1'b0;
      end else begin
         if (ratio_wr) ratio_q <= wdata[CFG_W-1:0];
         if (hold_wr)  hold_q  <= wdata[0];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_CNT)        rdata = cnt_rd;
      else if (addr == A_RATIO) rdata = {{(DATA_W-CFG_W){1'b0}}, ratio_q};
      else if (addr == A_HOLD)  rdata = {{(DATA_W-1){1'b0}}, hold_q};
   end

   assign ratio = ratio_q;
   assign hold  = hold_q;

   // R9
   cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n) !ratio_wr |=> $stable(ratio));
endmodule

// File: rtl/us_timebase.sv
module us_timebase #(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 32,
   parameter int          FIELD_W   = 8,
   parameter int          CNT_W     = 32,
   parameter int unsigned RST_RATIO = 'h000B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wen,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              us_tick
);
   localparam int CFG_W = 2 * FIELD_W;

   generate
      if (FIELD_W < 1 || CFG_W >= DATA_W || CNT_W < 1 || CNT_W > DATA_W || ADDR_W < 7) begin : g_bad
         $error("us_timebase: parameter combination out of range");
      end
   endgenerate

   logic [CFG_W-1:0]  ratio;
   logic              hold;
   logic              ratio_wr;
   logic              step;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] cnt_rd;

   generate
      if (CNT_W < DATA_W) begin : g_ext
         assign cnt_rd = {{(DATA_W-CNT_W){1'b0}}, cnt};
      end else begin : g_full
         assign cnt_rd = cnt;
      end
   endgenerate

   us_regfile #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W), .RST_RATIO(RST_RATIO)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wen(reg_wen), .wdata(reg_wdata),
      .cnt_rd(cnt_rd), .ratio(ratio), .hold(hold), .ratio_wr(ratio_wr), .rdata(reg_rdata)
   );

   us_ratio_accum #(.FIELD_W(FIELD_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .ratio(ratio), .clr(ratio_wr), .step(step), .tick(us_tick)
   );

   us_counter #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .inc(step), .hold(hold), .cnt(cnt)
   );
endmodule

// File: tb/us_timebase_test.sv
module us_timebase_test;
   localparam int CLK_PERIOD = 10;
   localparam int TB_CNT_W   = 12;
   localparam int CNT_MOD    = 1 << TB_CNT_W;
   localparam logic [7:0] A_CNT = 8'h10, A_RAT = 8'h14, A_HLD = 8'h4C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = A_CNT;
   logic        reg_wen = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        us_tick;

   us_timebase #(.CNT_W(TB_CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .us_tick(us_tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // reference model of the requirements
   logic [15:0] m_cfg = 16'h000B;
   int          m_acc = 0, m_cnt = 0;
   bit          m_frz = 1'b0;
   bit          exp_q[$];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = 16'h000B; m_acc = 0; m_cnt = 0; m_frz = 1'b0;
      end else begin
         int dvd, dvs, nacc;
         bit fire, old_frz;
         dvd = int'(m_cfg[15:8]) + 1;
         dvs = int'(m_cfg[7:0]) + 1;
         nacc = m_acc + dvd;
         fire = 1'b0;
         old_frz = m_frz;
         if (dvd >= dvs) begin fire = 1'b1; nacc = 0; end
         else if (nacc >= dvs) begin fire = 1'b1; nacc = nacc - dvs; end
         if (reg_wen && reg_addr == A_RAT) begin
            m_cfg = reg_wdata[15:0]; nacc = 0; fire = 1'b0;
         end
         if (reg_wen && reg_addr == A_HLD) m_frz = reg_wdata[0];
         m_acc = nacc;
         if (fire && !old_frz) m_cnt = (m_cnt + 1) % CNT_MOD;
         exp_q.push_back(fire);
      end
   end

   // monitor: pops one expectation per edge and compares tick and counter
   always @(negedge clk) begin
      #2;
      if (rst_n && exp_q.size() > 0) begin
         bit e;
         e = exp_q.pop_front();
         chk(us_tick == e, cur_req, {31'b0, us_tick}, {31'b0, e});
         if (reg_addr == A_CNT)
            chk(reg_rdata == 32'(m_cnt), {cur_req, "/R6"}, reg_rdata, 32'(m_cnt));
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      @(negedge clk);
      reg_wen = 1'b0; reg_addr = A_CNT;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
      reg_addr = A_CNT;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 32'(n_chk), 32'(0));
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, a, b;
      repeat (3) @(negedge clk);
      // R1: reset state before the first edge after release
      chk(us_tick == 1'b0, "R1", {31'b0, us_tick}, 32'h0);
      reg_addr = A_RAT; #1 chk(reg_rdata == 32'h000B, "R1", reg_rdata, 32'h000B);
      reg_addr = A_HLD; #1 chk(reg_rdata == 32'h0, "R1", reg_rdata, 32'h0);
      reg_addr = A_CNT; #1 chk(reg_rdata == 32'h0, "R1", reg_rdata, 32'h0);
      rst_n = 1'b1;

      cur_req = "R2"; run(12 * 8 + 3);

      cur_req = "R4"; wr(A_RAT, 32'h000C); run(13 * 6);
      wr(A_RAT, 32'h0019); run(26 * 4);

      cur_req = "R3"; wr(A_RAT, 32'h045F); run(96 * 4);

      cur_req = "R5"; wr(A_RAT, 32'h0707); run(20);
      wr(A_RAT, 32'h0502); run(20);

      // R8: ratio write on an edge where a tick is due
      cur_req = "R8"; wr(A_RAT, 32'h000B); run(5);
      do begin @(posedge clk); #1; end while (m_acc != 11);
      wr(A_RAT, 32'h000B);
      chk(us_tick == 1'b0, "R8", {31'b0, us_tick}, 32'h0);
      run(30);
      do begin @(posedge clk); #1; end while (m_acc != 4);
      wr(A_RAT, 32'h000C); run(40);

      // R7: hold set on an edge that also ticks
      cur_req = "R7"; wr(A_RAT, 32'h000B);
      do begin @(posedge clk); #1; end while (m_acc != 11);
      wr(A_HLD, 32'h1);
      rd(A_HLD, v); chk(v == 32'h1, "R7", v, 32'h1);
      rd(A_CNT, a); run(40); rd(A_CNT, b);
      chk(a == b, "R7", b, a);

      // R9: ignored writes and unused bits, checked while held
      cur_req = "R9";
      wr(A_CNT, 32'hFFFF_FFFF);
      rd(A_CNT, v); chk(v == a, "R9", v, a);
      wr(A_HLD, 32'hFFFF_FFFF);
      rd(A_HLD, v); chk(v == 32'h1, "R9", v, 32'h1);
      wr(A_RAT, 32'hABCD_000B);
      rd(A_RAT, v); chk(v == 32'h0000_000B, "R9", v, 32'h0000_000B);
      rd(8'h20, v); chk(v == 32'h0, "R9", v, 32'h0);
      rd(8'h48, v); chk(v == 32'h0, "R9", v, 32'h0);
      rd(8'h00, v); chk(v == 32'h0, "R9", v, 32'h0);
      cur_req = "R7"; wr(A_HLD, 32'h0); run(40);
      rd(A_CNT, v); chk(v != a, "R7", v, a);

      // R6: wrap with a tick on every edge
      cur_req = "R6"; wr(A_RAT, 32'h0000);
      run(CNT_MOD + 50);
      rd(A_CNT, v); chk(v < 32'(CNT_MOD), "R6", v, 32'(CNT_MOD));

      run(3);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule